// File: doc/BRIEF.md
# Endpoint FIFO CPU Access Port

This block is the processor-facing window onto the packet buffers of a device-side serial bus controller. A small control register picks which endpoint buffer the processor is working on, sets whether the data window is 8 or 16 bits wide, and sets the byte order within a 16-bit word. A data window then lets the processor read received bytes out of an OUT buffer or write outgoing bytes into an IN buffer. Each endpoint has its own read pointer and its own write pointer. The selected pointer advances by the number of bytes each access moves.

The access width is the logical OR of three sources: the port's own 8-bit bit, the selected endpoint's 8-bit configuration bit, and an external width strap. A rewind strobe in the control register restarts a buffer. It resets the read pointer of an OUT buffer that holds valid data, or the write pointer of an IN buffer that is not yet valid. A byte-wide fill port stands in for the packet engine that loads received data.

Top module: `epfifo_cpu_port`

## Requirements
- R1: After reset the control register reads 0, so endpoint 0 is selected in 16-bit unswapped mode, and every read and write pointer is 0.
- R2: A control write stores the endpoint select from bits 3:0, the 8-bit mode bit from bit 4 and the byte swap bit from bit 5, and these read back at the same positions. Bit 15 is the rewind strobe and always reads 0. All other bits read 0, and the fields keep their values until the next control write.
- R3: The data window is 8 bits wide when the port's 8-bit bit, the selected endpoint's 8-bit configuration bit or the width strap is 1. It is 16 bits wide only when all three are 0.
- R4: While the width strap is 1 the 8-bit mode bit reads back as 0. Its stored value shows again once the strap returns to 0.
- R5: In 16-bit mode with swap at 0, bits 7:0 carry the byte at the pointer and bits 15:8 carry the byte at the pointer plus 1. With swap at 1 the two lanes are exchanged.
- R6: In 8-bit mode, reads present the byte at the pointer on bits 7:0 with bits 15:8 at 0. Writes store only bits 7:0, and the swap bit has no effect.
- R7: Each accepted access advances the active pointer by 1 in 8-bit mode and by 2 in 16-bit mode, modulo the buffer size.
- R8: An endpoint whose direction bit is 0 is OUT: reads advance its read pointer and writes are ignored. An endpoint whose direction bit is 1 is IN: writes store data and advance its write pointer, while reads return 0 and move nothing.
- R9: A rewind aimed at an OUT endpoint resets its read pointer to 0 when that endpoint's valid flag is 1, and has no effect when the flag is 0.
- R10: A rewind aimed at an IN endpoint resets its write pointer to 0, which is the same as clearing the buffer, when its valid flag is 0. It has no effect when the flag is 1.
- R11: The rewind applies to the endpoint named in the same control write. Data strobes in a cycle that carries a control write are ignored.
- R12: A fill-port write stores one byte at the given endpoint and address and leaves every pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_strap | input | 1 | External strap forcing 8-bit access |
| ep_dir | input | NUM_EP | Per-endpoint direction, 1 = IN |
| ep_narrow | input | NUM_EP | Per-endpoint 8-bit configuration |
| ep_valid | input | NUM_EP | Per-endpoint buffer-valid flag |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control register readback |
| dat_wr | input | 1 | Data window write strobe |
| dat_wdata | input | 16 | Data window write data |
| dat_rd | input | 1 | Data window read strobe (pops the presented word) |
| dat_rdata | output | 16 | Word at the selected read pointer |
| se_wr | input | 1 | Fill-port byte write strobe |
| se_ep | input | log2(NUM_EP) | Fill-port endpoint |
| se_addr | input | log2(BUF_BYTES) | Fill-port byte address |
| se_byte | input | 8 | Fill-port byte |

## Verification
On every cycle the assertions check the pointer step of each accepted read and write, the stability of the selected pointers across control writes and ignored data strobes, and the two rewind outcomes. They also check that the upper lane is 0 in 8-bit mode, that IN reads return 0, that the mode bit is hidden under the strap, and that the control fields hold between writes. Which bytes sit in which lane, whether a swapped or narrow write landed at the right address, and whether a rewind that did nothing really left the written data alone can be seen only through the bench's scenarios. In those scenarios the direction is flipped and the buffers are read back against a behavioural model.

// File: rtl/epfifo_cpu_port.sv
module epfifo_cpu_port #(
  parameter int NUM_EP    = 16,
  parameter int BUF_BYTES = 32,
  localparam int SEL_W    = $clog2(NUM_EP),
  localparam int PTR_W    = $clog2(BUF_BYTES),
  localparam int MEM_W    = SEL_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              width_strap,
  input  logic [NUM_EP-1:0] ep_dir,
  input  logic [NUM_EP-1:0] ep_narrow,
  input  logic [NUM_EP-1:0] ep_valid,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_wdata,
  output logic [15:0]       ctl_rdata,
  input  logic              dat_wr,
  input  logic [15:0]       dat_wdata,
  input  logic              dat_rd,
  output logic [15:0]       dat_rdata,
  input  logic              se_wr,
  input  logic [SEL_W-1:0]  se_ep,
  input  logic [PTR_W-1:0]  se_addr,
  input  logic [7:0]        se_byte
);

  logic [SEL_W-1:0] sel;
  logic             mode8, swap;
  logic [PTR_W-1:0] rp [NUM_EP];
  logic [PTR_W-1:0] wp [NUM_EP];
  logic [7:0]       mem [2**MEM_W];

  wire [SEL_W-1:0] wsel   = ctl_wdata[SEL_W-1:0];
  wire             rewind = ctl_wdata[15];
  wire             narrow = mode8 | ep_narrow[sel] | width_strap;
  wire             is_in  = ep_dir[sel];

  wire [PTR_W-1:0] rp_s = rp[sel];
  wire [PTR_W-1:0] wp_s = wp[sel];
  wire [PTR_W-1:0] rp_n = rp_s + PTR_W'(1);
  wire [PTR_W-1:0] wp_n = wp_s + PTR_W'(1);
  wire [PTR_W-1:0] step = narrow ? PTR_W'(1) : PTR_W'(2);

  wire rd_go = dat_rd & ~ctl_wr & ~is_in;
  wire wr_go = dat_wr & ~ctl_wr & is_in;

  wire [7:0] b0 = mem[{sel, rp_s}];
  wire [7:0] b1 = mem[{sel, rp_n}];

  assign dat_rdata = is_in  ? 16'h0000 :
                     narrow ? {8'h00, b0} :
                     swap   ? {b0, b1} : {b1, b0};

  assign ctl_rdata = {10'b0, swap, mode8 & ~width_strap, 4'(sel)};

  wire [7:0] lo_byte = (swap && !narrow) ? dat_wdata[15:8] : dat_wdata[7:0];
  wire [7:0] hi_byte = swap ? dat_wdata[7:0] : dat_wdata[15:8];

  logic unused_ctl_bits;
  assign unused_ctl_bits = ^ctl_wdata[14:6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel   <= '0;
      mode8 <= 1'b0;
      swap  <= 1'b0;
    end else if (ctl_wr) begin
      sel   <= wsel;
      mode8 <= ctl_wdata[4];
      swap  <= ctl_wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_EP; i++) begin
      if (!rst_n) begin
        rp[i] <= '0;
        wp[i] <= '0;
      end else if (ctl_wr) begin
        if (rewind && wsel == SEL_W'(i)) begin
          if (!ep_dir[i] && ep_valid[i]) rp[i] <= '0;
          if (ep_dir[i] && !ep_valid[i]) wp[i] <= '0;
        end
      end else if (sel == SEL_W'(i)) begin
        if (rd_go) rp[i] <= rp_s + step;
        if (wr_go) wp[i] <= wp_s + step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (se_wr) mem[{se_ep, se_addr}] <= se_byte;
    if (wr_go) begin
      mem[{sel, wp_s}] <= lo_byte;
      if (!narrow) mem[{sel, wp_n}] <= hi_byte;
    end
  end

endmodule

module epfifo_cpu_port_chk #(
  parameter int NUM_EP = 16,
  parameter int SEL_W  = 4,
  parameter int PTR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              width_strap,
  input logic [NUM_EP-1:0] ep_dir,
  input logic [NUM_EP-1:0] ep_valid,
  input logic              ctl_wr,
  input logic [15:0]       ctl_wdata,
  input logic [15:0]       ctl_rdata,
  input logic              dat_wr,
  input logic              dat_rd,
  input logic [15:0]       dat_rdata,
  input logic [SEL_W-1:0]  sel,
  input logic              narrow,
  input logic              is_in,
  input logic [PTR_W-1:0]  rp_s,
  input logic [PTR_W-1:0]  wp_s
);
  wire [SEL_W-1:0] tgt = ctl_wdata[SEL_W-1:0];

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_rdata[3:0]) && $stable(ctl_rdata[5])); // R2
  AST_REWIND_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata[15:6] == 10'd0); // R2
  AST_STRAP_HIDES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    width_strap |-> !ctl_rdata[4] && narrow); // R4
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> dat_rdata[15:8] == 8'h00); // R6
  AST_IN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_in |-> dat_rdata == 16'h0000); // R8
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !ctl_wr && !is_in) |=> rp_s == $past(rp_s) + ($past(narrow) ? PTR_W'(1) : PTR_W'(2))); // R7
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !ctl_wr && is_in) |=> wp_s == $past(wp_s) + ($past(narrow) ? PTR_W'(1) : PTR_W'(2))); // R7
  AST_OUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !ctl_wr && !is_in) |=> $stable(wp_s)); // R8
  AST_IN_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !ctl_wr && is_in) |=> $stable(rp_s)); // R8
  AST_CTL_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[15] && tgt == sel) |=> $stable(rp_s) && $stable(wp_s)); // R11
  AST_REWIND_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[15] && !ep_dir[tgt] && ep_valid[tgt]) |=> rp_s == '0); // R9
  AST_REWIND_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[15] && ep_dir[tgt] && !ep_valid[tgt]) |=> wp_s == '0); // R10
  AST_REWIND_OUT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && tgt == sel && !ep_dir[tgt] && !ep_valid[tgt]) |=> $stable(rp_s)); // R9
endmodule

bind epfifo_cpu_port epfifo_cpu_port_chk #(.NUM_EP(NUM_EP), .SEL_W(SEL_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .width_strap(width_strap), .ep_dir(ep_dir), .ep_valid(ep_valid),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .dat_wr(dat_wr),
  .dat_rd(dat_rd), .dat_rdata(dat_rdata), .sel(sel), .narrow(narrow), .is_in(is_in),
  .rp_s(rp_s), .wp_s(wp_s)
);

// File: tb/epfifo_cpu_port_test.sv
module epfifo_cpu_port_test;
  localparam int NE = 16;
  localparam int NB = 32;

  logic clk = 0, rst_n = 0, width_strap = 0;
  logic [NE-1:0] ep_dir = '0, ep_narrow = '0, ep_valid = '0;
  logic ctl_wr = 0, dat_wr = 0, dat_rd = 0, se_wr = 0;
  logic [15:0] ctl_wdata = '0, dat_wdata = '0;
  logic [15:0] ctl_rdata, dat_rdata;
  logic [3:0] se_ep = '0;
  logic [4:0] se_addr = '0;
  logic [7:0] se_byte = '0;

  epfifo_cpu_port #(.NUM_EP(NE), .BUF_BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .width_strap(width_strap), .ep_dir(ep_dir),
    .ep_narrow(ep_narrow), .ep_valid(ep_valid), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .dat_rdata(dat_rdata), .se_wr(se_wr), .se_ep(se_ep), .se_addr(se_addr), .se_byte(se_byte)
  );

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  int m_sel, m_rp[NE], m_wp[NE];
  bit m_mode, m_swap;
  int m_mem[NE][NB];

  function automatic int pre(int e, int a);
    return (e * 37 + a * 5 + 1) & 255;
  endfunction

  function automatic bit m_narrow();
    return m_mode || ep_narrow[m_sel] || width_strap;
  endfunction

  function automatic logic [15:0] m_data();
    int a, b;
    a = m_rp[m_sel];
    b = (a + 1) % NB;
    if (ep_dir[m_sel]) return 16'h0000;
    if (m_narrow()) return 16'(m_mem[m_sel][a]);
    if (m_swap) return 16'((m_mem[m_sel][a] << 8) | m_mem[m_sel][b]);
    return 16'((m_mem[m_sel][b] << 8) | m_mem[m_sel][a]);
  endfunction

  function automatic logic [15:0] m_ctl();
    return 16'((m_swap ? 32 : 0) + ((m_mode && !width_strap) ? 16 : 0) + m_sel);
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_mode = 0; m_swap = 0;
      for (int i = 0; i < NE; i++) begin m_rp[i] = 0; m_wp[i] = 0; end
    end else begin
      bit n;
      int s, w;
      n = m_narrow();
      s = m_sel;
      if (se_wr) m_mem[se_ep][se_addr] = se_byte;
      if (ctl_wr) begin
        int t;
        t = ctl_wdata[3:0];
        if (ctl_wdata[15]) begin
          if (!ep_dir[t] && ep_valid[t]) m_rp[t] = 0;
          if (ep_dir[t] && !ep_valid[t]) m_wp[t] = 0;
        end
        m_sel = t; m_mode = ctl_wdata[4]; m_swap = ctl_wdata[5];
      end else begin
        if (dat_rd && !ep_dir[s]) m_rp[s] = (m_rp[s] + (n ? 1 : 2)) % NB;
        if (dat_wr && ep_dir[s]) begin
          w = m_wp[s];
          if (n) m_mem[s][w] = dat_wdata[7:0];
          else if (m_swap) begin
            m_mem[s][w] = dat_wdata[15:8]; m_mem[s][(w + 1) % NB] = dat_wdata[7:0];
          end else begin
            m_mem[s][w] = dat_wdata[7:0]; m_mem[s][(w + 1) % NB] = dat_wdata[15:8];
          end
          m_wp[s] = (w + (n ? 1 : 2)) % NB;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({cur_req, " per-cycle ctl"}, ctl_rdata, m_ctl());
      chk({cur_req, " per-cycle data"}, dat_rdata, m_data());
    end
  end

  task automatic ctl(logic [15:0] w);
    @(negedge clk); #1; ctl_wr = 1; ctl_wdata = w;
    @(negedge clk); #1; ctl_wr = 0;
  endtask
  task automatic rd();
    @(negedge clk); #1; dat_rd = 1;
    @(negedge clk); #1; dat_rd = 0;
  endtask
  task automatic wr(logic [15:0] d);
    @(negedge clk); #1; dat_wr = 1; dat_wdata = d;
    @(negedge clk); #1; dat_wr = 0;
  endtask
  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    settle();
    chk("R1 reset ctl", ctl_rdata, 16'h0000);

    for (int e = 0; e < NE; e++)
      for (int a = 0; a < NB; a++) begin
        @(negedge clk); #1; se_wr = 1; se_ep = 4'(e); se_addr = 5'(a); se_byte = 8'(pre(e, a));
      end
    @(negedge clk); #1; se_wr = 0;
    cmp_on = 1;
    settle();
    chk("R1 R12 reset pointer ep0", dat_rdata, 16'((pre(0, 1) << 8) | pre(0, 0)));

    cur_req = "R2";
    ctl(16'h8035);
    chk("R2 readback", ctl_rdata, 16'h0035);

    cur_req = "R5"; ep_valid[2] = 1;
    ctl(16'h0002);
    chk("R5 little", dat_rdata, 16'((pre(2, 1) << 8) | pre(2, 0)));
    rd();
    chk("R7 step2", dat_rdata, 16'((pre(2, 3) << 8) | pre(2, 2)));
    ctl(16'h0022);
    chk("R5 swapped", dat_rdata, 16'((pre(2, 2) << 8) | pre(2, 3)));
    cur_req = "R9";
    ctl(16'h8002);
    chk("R9 rewind out", dat_rdata, 16'((pre(2, 1) << 8) | pre(2, 0)));
    rd(); rd(); ep_valid[2] = 0;
    ctl(16'h8002);
    chk("R9 rewind blocked", dat_rdata, 16'((pre(2, 5) << 8) | pre(2, 4)));

    cur_req = "R3"; ep_narrow[3] = 1;
    ctl(16'h0003);
    chk("R3 ep narrow", dat_rdata, 16'(pre(3, 0)));
    rd();
    chk("R7 step1", dat_rdata, 16'(pre(3, 1)));
    ctl(16'h0023);
    chk("R6 swap ignored", dat_rdata, 16'(pre(3, 1)));

    cur_req = "R4";
    ctl(16'h0011);
    chk("R4 mode8 shown", ctl_rdata, 16'h0011);
    width_strap = 1; settle();
    chk("R4 strap masks", ctl_rdata, 16'h0001);
    chk("R3 strap narrow", dat_rdata, 16'(pre(1, 0)));
    width_strap = 0; settle();
    chk("R4 strap released", ctl_rdata, 16'h0011);

    cur_req = "R7";
    ctl(16'h0004);
    for (int k = 0; k < NB / 2; k++) rd();
    chk("R7 wrap", dat_rdata, 16'((pre(4, 1) << 8) | pre(4, 0)));
    ctl(16'h0014);
    rd(); rd(); rd();
    chk("R7 narrow steps", dat_rdata, 16'(pre(4, 3)));

    cur_req = "R8"; ep_dir[6] = 1;
    ctl(16'h0006);
    chk("R8 in reads zero", dat_rdata, 16'h0000);
    wr(16'hA1B2);
    ctl(16'h0026); wr(16'hC3D4);
    ctl(16'h0016); wr(16'hFFE5);
    rd();
    ep_dir[6] = 0;
    ctl(16'h0006);
    chk("R8 in data little", dat_rdata, 16'hA1B2);
    rd();
    chk("R5 in data swapped", dat_rdata, 16'hD4C3);
    rd();
    chk("R6 narrow write", dat_rdata, 16'((pre(6, 5) << 8) | 8'hE5));
    ctl(16'h0007);
    wr(16'h1234);
    chk("R8 out write ignored", dat_rdata, 16'((pre(7, 1) << 8) | pre(7, 0)));

    cur_req = "R10"; ep_dir[8] = 1; ep_valid[8] = 0;
    ctl(16'h0008);
    wr(16'h1111); wr(16'h2222);
    ctl(16'h8008);
    wr(16'h3333);
    ep_valid[8] = 1;
    ctl(16'h8008);
    wr(16'h4444);
    ep_dir[8] = 0;
    ctl(16'h0008);
    chk("R10 rewind in", dat_rdata, 16'h3333);
    rd();
    chk("R10 rewind in blocked", dat_rdata, 16'h4444);
    rd();
    chk("R10 untouched", dat_rdata, 16'((pre(8, 5) << 8) | pre(8, 4)));

    cur_req = "R11";
    ctl(16'h0009);
    @(negedge clk); #1; ctl_wr = 1; ctl_wdata = 16'h0009; dat_rd = 1;
    @(negedge clk); #1; ctl_wr = 0; dat_rd = 0;
    chk("R11 strobe during ctl", dat_rdata, 16'((pre(9, 1) << 8) | pre(9, 0)));

    cur_req = "R12";
    @(negedge clk); #1; se_wr = 1; se_ep = 4'd9; se_addr = 5'd0; se_byte = 8'h77;
    @(negedge clk); #1; se_wr = 0;
    chk("R12 fill byte", dat_rdata, 16'((pre(9, 1) << 8) | 8'h77));

    settle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule